// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

A small word-addressed on-chip memory shared by several request ports. Each word holds a data value, a full/empty tag and a lock bit. Processors use it for producer/consumer handoff. A consumer's read waits until the word has been filled. A producer's write waits until the previous value has been consumed. Every operation goes through two phases. At issue, the requester presents an operation, an address, store data and a transaction tag. The memory either accepts the operation or stalls that port. Later, a commit naming the tag makes the effect visible, or a squash naming the tag discards the operation.

Memory contents and tags change only at commit. An accepted operation locks its word from issue until it commits or is squashed, so other ports cannot slip in between the check and the update. Load results come back on a single return channel, marked with the transaction tag, one cycle after the commit edge. One new issue is accepted per cycle, and lower-numbered ports win.

Top module: `fe_sync_mem`

## Requirements
- R1: Operation code 2 (synchronizing load) stalls while the word is empty. Once the word is full it is accepted. At commit it returns the word's data and marks the word empty.
- R2: Operation code 3 (synchronizing store) stalls while the word is full. Once the word is empty it is accepted. At commit it writes the store data and marks the word full.
- R3: Operation code 4 (future load) stalls while the word is empty. At commit it returns the data and leaves the tag full.
- R4: Operation code 5 (tag-clearing load) never stalls on the tag. At commit it returns the data and marks the word empty.
- R5: Operation code 6 (tag-setting store) never stalls on the tag. At commit it writes the data and marks the word full.
- R6: An accepted operation locks its word. Any issue to a locked word stalls until the locking operation commits or is squashed. The lock is seen from the cycle after that commit or squash.
- R7: Data and tag change only at a commit. A load's result appears on rd_valid_o, rd_tag_o and rd_data_o in the cycle after the commit edge. The result is the value held before that commit.
- R8: A squash naming a pending tag discards that operation and unlocks its word. The word's data and full/empty tag are left unchanged. If a commit and a squash name the same tag in one cycle, the squash wins.
- R9: Codes 0 and 7 (plain loads) and code 1 (plain store) ignore the full/empty tag. They never change the tag, but they still stall on a locked word.
- R10: At most one issue is accepted per cycle. It goes to the lowest-numbered port whose request is eligible. Every other requesting port sees its stall asserted.
- R11: An issue whose transaction tag is still pending stalls.
- R12: After reset, every word holds zero, is empty and is unlocked, and no result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | NPORTS | Issue request per port |
| iss_op_i | input | NPORTS*3 | Operation code per port |
| iss_addr_i | input | NPORTS*AW | Word address per port |
| iss_data_i | input | NPORTS*DW | Store data per port |
| iss_tag_i | input | NPORTS*TW | Transaction tag per port |
| stall_o | output | NPORTS | Issue not accepted this cycle |
| cmt_valid_i | input | 1 | Commit request |
| cmt_tag_i | input | TW | Tag to commit |
| sq_valid_i | input | 1 | Squash request |
| sq_tag_i | input | TW | Tag to squash |
| rd_valid_o | output | 1 | Load result valid |
| rd_tag_o | output | TW | Tag of the returned load |
| rd_data_o | output | DW | Load result data |

## Verification
The hardest case to reach is a word that stays locked between issue and commit while a second request arrives. The bench therefore holds back the commit for an accepted plain load. It then issues to the same word and checks for a stall, and issues to a neighbouring word and checks that it is accepted. A speculative store is squashed before it commits, and the bench checks both the unlock and the unchanged data and tag through later loads. The arbitration cases drive both ports in one cycle. In one case port 0 is eligible. In the other, port 0 is waiting on an empty word, so port 1 must be served even though it has the lower priority.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;
  typedef enum logic [2:0] {
    OP_LD      = 3'd0,
    OP_ST      = 3'd1,
    OP_SYNC_LD = 3'd2,
    OP_SYNC_ST = 3'd3,
    OP_FUT_LD  = 3'd4,
    OP_CLR_LD  = 3'd5,
    OP_SET_ST  = 3'd6,
    OP_LD_ALT  = 3'd7
  } fe_op_e;

  function automatic logic fe_ok(input logic [2:0] op, input logic full);
    case (op)
      OP_SYNC_LD, OP_FUT_LD: fe_ok = full;
      OP_SYNC_ST:            fe_ok = !full;
      default:               fe_ok = 1'b1;
    endcase
  endfunction

  function automatic logic is_load(input logic [2:0] op);
    is_load = !(op == OP_ST || op == OP_SYNC_ST || op == OP_SET_ST);
  endfunction
endpackage

// File: rtl/fe_arbiter.sv
module fe_arbiter #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) grant_o = N'(1) << i;
    end
  end

  assert_one_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_grant_when_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|grant_o));
endmodule

// File: rtl/fe_txn_table.sv
module fe_txn_table #(
  parameter int TW = 3,
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int NT = 1 << TW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [2:0]    wr_op_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cmt_valid_i,
  input  logic [TW-1:0] cmt_tag_i,
  input  logic          sq_valid_i,
  input  logic [TW-1:0] sq_tag_i,
  output logic [NT-1:0] busy_o,
  output logic          cmt_en_o,
  output logic [2:0]    cmt_op_o,
  output logic [AW-1:0] cmt_addr_o,
  output logic [DW-1:0] cmt_data_o,
  output logic          sq_en_o,
  output logic [AW-1:0] sq_addr_o
);
  logic [NT-1:0] vld_q;
  logic [2:0]    op_q   [NT];
  logic [AW-1:0] addr_q [NT];
  logic [DW-1:0] data_q [NT];

  assign busy_o     = vld_q;
  assign sq_en_o    = sq_valid_i && vld_q[sq_tag_i];
  assign cmt_en_o   = cmt_valid_i && vld_q[cmt_tag_i] && !(sq_en_o && sq_tag_i == cmt_tag_i);
  assign cmt_op_o   = op_q[cmt_tag_i];
  assign cmt_addr_o = addr_q[cmt_tag_i];
  assign cmt_data_o = data_q[cmt_tag_i];
  assign sq_addr_o  = addr_q[sq_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < NT; i++) begin
        op_q[i]   <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (cmt_en_o) vld_q[cmt_tag_i] <= 1'b0;
      if (sq_en_o)  vld_q[sq_tag_i]  <= 1'b0;
      if (wr_en_i) begin
        vld_q[wr_tag_i]  <= 1'b1;
        op_q[wr_tag_i]   <= wr_op_i;
        addr_q[wr_tag_i] <= wr_addr_i;
        data_q[wr_tag_i] <= wr_data_i;
      end
    end
  end

  assert_no_double_alloc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !vld_q[wr_tag_i]);
  assert_sq_over_cmt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_en_o && cmt_valid_i && cmt_tag_i == sq_tag_i) |-> !cmt_en_o);
endmodule

// File: rtl/fe_word_store.sv
module fe_word_store
  import fe_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_en_i,
  input  logic [AW-1:0]    lock_addr_i,
  input  logic             cmt_en_i,
  input  logic [2:0]       cmt_op_i,
  input  logic [AW-1:0]    cmt_addr_i,
  input  logic [DW-1:0]    cmt_data_i,
  input  logic             rel_en_i,
  input  logic [AW-1:0]    rel_addr_i,
  output logic [DEPTH-1:0] full_o,
  output logic [DEPTH-1:0] lock_o,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[cmt_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= '0;
      lock_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (rel_en_i) lock_o[rel_addr_i] <= 1'b0;
      if (cmt_en_i) begin
        lock_o[cmt_addr_i] <= 1'b0;
        case (cmt_op_i)
          OP_ST:      mem_q[cmt_addr_i] <= cmt_data_i;
          OP_SYNC_LD,
          OP_CLR_LD:  full_o[cmt_addr_i] <= 1'b0;
          OP_SYNC_ST,
          OP_SET_ST: begin
            mem_q[cmt_addr_i]  <= cmt_data_i;
            full_o[cmt_addr_i] <= 1'b1;
          end
          default: ;
        endcase
      end
      if (lock_en_i) lock_o[lock_addr_i] <= 1'b1;
    end
  end

  assert_tag_only_at_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmt_en_i |=> $stable(full_o));
  assert_sync_ld_empties_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_en_i && cmt_op_i == OP_SYNC_LD) |=> !full_o[$past(cmt_addr_i)]);
  assert_sync_st_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_en_i && cmt_op_i == OP_SYNC_ST) |=> full_o[$past(cmt_addr_i)]);
  assert_commit_unlocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_en_i |=> !lock_o[$past(cmt_addr_i)]);
  assert_squash_unlocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_en_i |=> !lock_o[$past(rel_addr_i)]);
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_mem_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  parameter int TW     = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int NT    = 1 << TW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NPORTS-1:0]    iss_valid_i,
  input  logic [NPORTS*3-1:0]  iss_op_i,
  input  logic [NPORTS*AW-1:0] iss_addr_i,
  input  logic [NPORTS*DW-1:0] iss_data_i,
  input  logic [NPORTS*TW-1:0] iss_tag_i,
  output logic [NPORTS-1:0]    stall_o,
  input  logic                 cmt_valid_i,
  input  logic [TW-1:0]        cmt_tag_i,
  input  logic                 sq_valid_i,
  input  logic [TW-1:0]        sq_tag_i,
  output logic                 rd_valid_o,
  output logic [TW-1:0]        rd_tag_o,
  output logic [DW-1:0]        rd_data_o
);
  logic [NPORTS-1:0] elig, grant;
  logic [DEPTH-1:0]  full, lock;
  logic [NT-1:0]     busy;
  logic              iss_en;
  logic [2:0]        sel_op;
  logic [AW-1:0]     sel_addr;
  logic [DW-1:0]     sel_data;
  logic [TW-1:0]     sel_tag;
  logic              cmt_en, sq_en;
  logic [2:0]        cmt_op;
  logic [AW-1:0]     cmt_addr, sq_addr;
  logic [DW-1:0]     cmt_data, mem_rd;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [TW-1:0] tag;
    assign op   = iss_op_i[p*3 +: 3];
    assign addr = iss_addr_i[p*AW +: AW];
    assign tag  = iss_tag_i[p*TW +: TW];
    assign elig[p] = iss_valid_i[p] && !lock[addr] && !busy[tag] && fe_ok(op, full[addr]);
    assign stall_o[p] = iss_valid_i[p] && !grant[p];
  end

  fe_arbiter #(.N(NPORTS)) u_arb (
    .clk_i, .rst_ni, .req_i(elig), .grant_o(grant)
  );

  always_comb begin
    sel_op = '0; sel_addr = '0; sel_data = '0; sel_tag = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (grant[p]) begin
        sel_op   = iss_op_i[p*3 +: 3];
        sel_addr = iss_addr_i[p*AW +: AW];
        sel_data = iss_data_i[p*DW +: DW];
        sel_tag  = iss_tag_i[p*TW +: TW];
      end
    end
  end
  assign iss_en = |grant;

  fe_txn_table #(.TW(TW), .AW(AW), .DW(DW)) u_tbl (
    .clk_i, .rst_ni,
    .wr_en_i(iss_en), .wr_tag_i(sel_tag), .wr_op_i(sel_op),
    .wr_addr_i(sel_addr), .wr_data_i(sel_data),
    .cmt_valid_i, .cmt_tag_i, .sq_valid_i, .sq_tag_i,
    .busy_o(busy), .cmt_en_o(cmt_en), .cmt_op_o(cmt_op),
    .cmt_addr_o(cmt_addr), .cmt_data_o(cmt_data),
    .sq_en_o(sq_en), .sq_addr_o(sq_addr)
  );

  fe_word_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .lock_en_i(iss_en), .lock_addr_i(sel_addr),
    .cmt_en_i(cmt_en), .cmt_op_i(cmt_op), .cmt_addr_i(cmt_addr), .cmt_data_i(cmt_data),
    .rel_en_i(sq_en), .rel_addr_i(sq_addr),
    .full_o(full), .lock_o(lock), .rd_data_o(mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_tag_o   <= '0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= cmt_en && is_load(cmt_op);
      if (cmt_en && is_load(cmt_op)) begin
        rd_tag_o  <= cmt_tag_i;
        rd_data_o <= mem_rd;
      end
    end
  end

  assert_issue_locks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_en |=> lock[$past(sel_addr)]);
  assert_result_after_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmt_valid_i));
  assert_grant_unlocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock[sel_addr]) |-> $past(iss_en));
endmodule

// File: tb/fe_sync_mem_tb_top.sv
module fe_sync_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2, AW = 4, DW = 32, TW = 3;

  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          stall;
    logic          rv;
    logic [DW-1:0] rdata;
  } vec_t;

  // op codes: 0 ld, 1 st, 2 sync ld, 3 sync st, 4 future ld, 5 clear ld, 6 set st, 7 ld
  localparam vec_t VECS [16] = '{
    '{3'd4, 4'd1, 32'h0,  1'b1, 1'b0, 32'h0 },  // R3 empty stalls
    '{3'd2, 4'd1, 32'h0,  1'b1, 1'b0, 32'h0 },  // R1 empty stalls
    '{3'd3, 4'd1, 32'hA5, 1'b0, 1'b0, 32'h0 },  // R2 fills
    '{3'd3, 4'd1, 32'h11, 1'b1, 1'b0, 32'h0 },  // R2 full stalls
    '{3'd4, 4'd1, 32'h0,  1'b0, 1'b1, 32'hA5},  // R3 keeps full
    '{3'd2, 4'd1, 32'h0,  1'b0, 1'b1, 32'hA5},  // R1 empties
    '{3'd2, 4'd1, 32'h0,  1'b1, 1'b0, 32'h0 },  // R1 now empty
    '{3'd1, 4'd1, 32'h22, 1'b0, 1'b0, 32'h0 },  // R9 plain st
    '{3'd0, 4'd1, 32'h0,  1'b0, 1'b1, 32'h22},  // R9 plain ld on empty
    '{3'd4, 4'd1, 32'h0,  1'b1, 1'b0, 32'h0 },  // R9 plain st left empty
    '{3'd6, 4'd2, 32'h33, 1'b0, 1'b0, 32'h0 },  // R5
    '{3'd6, 4'd2, 32'h44, 1'b0, 1'b0, 32'h0 },  // R5 no stall when full
    '{3'd4, 4'd2, 32'h0,  1'b0, 1'b1, 32'h44},  // R5 data + full
    '{3'd5, 4'd2, 32'h0,  1'b0, 1'b1, 32'h44},  // R4
    '{3'd4, 4'd2, 32'h0,  1'b1, 1'b0, 32'h0 },  // R4 left empty
    '{3'd7, 4'd2, 32'h0,  1'b0, 1'b1, 32'h44}   // R9 code 7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]    iss_valid = '0;
  logic [NP*3-1:0]  iss_op = '0;
  logic [NP*AW-1:0] iss_addr = '0;
  logic [NP*DW-1:0] iss_data = '0;
  logic [NP*TW-1:0] iss_tag = '0;
  logic [NP-1:0]    stall;
  logic             cmt_valid = 1'b0, sq_valid = 1'b0;
  logic [TW-1:0]    cmt_tag = '0, sq_tag = '0;
  logic             rd_valid;
  logic [TW-1:0]    rd_tag;
  logic [DW-1:0]    rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fe_sync_mem dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op), .iss_addr_i(iss_addr),
    .iss_data_i(iss_data), .iss_tag_i(iss_tag), .stall_o(stall),
    .cmt_valid_i(cmt_valid), .cmt_tag_i(cmt_tag),
    .sq_valid_i(sq_valid), .sq_tag_i(sq_tag),
    .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [TW-1:0] t);
    iss_valid[p] = 1'b1;
    iss_op[p*3 +: 3] = op;
    iss_addr[p*AW +: AW] = a;
    iss_data[p*DW +: DW] = d;
    iss_tag[p*TW +: TW] = t;
  endtask

  // commit at next edge; return checked one cycle later
  task automatic commit(input logic [TW-1:0] t, input logic rv, input logic [DW-1:0] d,
                        input string req);
    @(negedge clk);
    iss_valid = '0;
    cmt_valid = 1'b1; cmt_tag = t;
    @(negedge clk);
    cmt_valid = 1'b0;
    chk(req, rd_valid, rv);
    if (rv) begin
      chk(req, rd_data, d);
      chk(req, rd_tag, t);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R12 stall", stall, 0);
    chk("R12 rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: word 9 zero and empty after reset
    drive(0, 3'd4, 4'd9, 0, 0); #1 chk("R12 empty", stall[0], 1);
    drive(0, 3'd0, 4'd9, 0, 0); #1 chk("R12 zero", stall[0], 0);
    commit(0, 1'b1, 32'h0, "R12 zero data");

    foreach (VECS[i]) begin
      @(negedge clk);
      drive(0, VECS[i].op, VECS[i].addr, VECS[i].data, 0);
      #1 chk($sformatf("vec %0d stall", i), stall[0], VECS[i].stall);
      if (!VECS[i].stall) commit(0, VECS[i].rv, VECS[i].rdata, $sformatf("vec %0d R7 result", i));
      else begin @(negedge clk); iss_valid = '0; end
    end

    // R6: hold a lock on word 5
    @(negedge clk);
    drive(0, 3'd0, 4'd5, 0, 1); #1 chk("R6 first accept", stall[0], 0);
    @(negedge clk);
    drive(0, 3'd1, 4'd5, 32'h55, 2); #1 chk("R6 locked word stalls", stall[0], 1);
    drive(0, 3'd1, 4'd6, 32'h66, 2); #1 chk("R6 other word ok", stall[0], 0);
    @(negedge clk);
    drive(0, 3'd0, 4'd3, 0, 1); #1 chk("R11 pending tag stalls", stall[0], 1);
    iss_valid = '0;
    commit(1, 1'b1, 32'h0, "R6 load of word 5");
    drive(0, 3'd1, 4'd5, 32'h55, 3); #1 chk("R6 unlocked after commit", stall[0], 0);
    commit(3, 1'b0, 0, "R6 store");
    commit(2, 1'b0, 0, "R6 store word 6");

    // R8: squash a sync store to word 7
    @(negedge clk);
    drive(0, 3'd3, 4'd7, 32'h77, 4); #1 chk("R8 sync st accept", stall[0], 0);
    @(negedge clk);
    iss_valid = '0;
    sq_valid = 1'b1; sq_tag = 4; cmt_valid = 1'b1; cmt_tag = 4;
    @(negedge clk);
    sq_valid = 1'b0; cmt_valid = 1'b0;
    chk("R8 squash beats commit", rd_valid, 0);
    drive(0, 3'd4, 4'd7, 0, 5); #1 chk("R8 tag still empty", stall[0], 1);
    drive(0, 3'd0, 4'd7, 0, 5); #1 chk("R8 unlocked", stall[0], 0);
    commit(5, 1'b1, 32'h0, "R8 data unchanged");
    commit(4, 1'b0, 0, "R8 squashed tag gone");

    // R10: both ports eligible
    @(negedge clk);
    drive(0, 3'd0, 4'd5, 0, 0);
    drive(1, 3'd0, 4'd6, 0, 1);
    #1 chk("R10 port0 wins", stall, 2'b10);
    @(negedge clk);
    iss_valid[0] = 1'b0;
    drive(1, 3'd0, 4'd6, 0, 1); #1 chk("R10 port1 later", stall, 2'b00);
    commit(0, 1'b1, 32'h55, "R10 port0 data");
    commit(1, 1'b1, 32'h66, "R10 port1 data");
    // R10: port0 ineligible (word 7 empty)
    @(negedge clk);
    drive(0, 3'd2, 4'd7, 0, 0);
    drive(1, 3'd0, 4'd6, 0, 1);
    #1 chk("R10 eligible port1 served", stall, 2'b01);
    commit(1, 1'b1, 32'h66, "R10 port1 served data");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule